// File: doc/BRIEF.md
# Interlaced Vertical Sync and Equalization Timer

This block produces the vertical timing windows for an interlaced video raster. Horizontal timing supplies it with a pulse once per half line and with the identifier of the field now being scanned. The block counts half lines from the start of each field. From that count it drives three windows: vertical sync, the equalization-pulse interval and the vertical colorburst enable. It also reports the position of the current field within a repeating four-field sequence.

Vertical sync and equalization each have a start offset for field 1 and another for field 2. Each has its own length in half lines, and equalization can be switched off. The colorburst window works in whole lines. Its start is measured from the top of the field, and its end is measured from the first line of the non-blank region. There is one start/end pair for each of the four fields in the sequence, and the field number picks the pair that applies. All configuration inputs are taken to be static while the block is counting.

Top module: `ilace_vtimer`

## Requirements
- R1: While reset is asserted, and after it is released until the first half-line tick, the field number is 0, the half-line count is 0 and the held field identifier is 0 (field 1).
- R2: Each `hl_tick` that is not a field boundary increases the half-line count h by one. The count saturates at 2^HL_W-1. In cycles without a tick, h and every other counting state stay as they are.
- R3: A field boundary is a tick on which `field_id` differs from the identifier the block holds. On a boundary, h restarts at 0 and the block takes the new identifier. A change of `field_id` in a cycle without a tick has no effect.
- R4: `field_no` advances by one modulo 4 on every field boundary, counting 0, 1, 2, 3, 0.
- R5: `vsync_o` is high exactly while s <= h < s+`vs_len`. The start code s is `vs_start_f1` when the held identifier is 0 and `vs_start_f2` when it is 1. A code of s therefore opens the window on half line s+1, counting the first half line as 1.
- R6: `eq_o` is high exactly while `eq_en` is 1 and e <= h < e+`eq_len`. The start code e is `eq_start_f1` for identifier 0 and `eq_start_f2` for identifier 1. With `eq_en` at 0, `eq_o` stays 0.
- R7: Let L = h/2, rounded down. `vburst_o` is high exactly while b <= L <= `nbr_line`+d. For field number k, b is bits [k*VBS_W +: VBS_W] of `vb_start_all` and d is bits [k*VBE_W +: VBE_W] of `vb_end_all`.
- R8: When the sync and equalization windows overlap, `vsync_o` and `eq_o` are both high in the same cycle, each following its own rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hl_tick | input | 1 | One-cycle pulse per half line |
| field_id | input | 1 | Field identifier from horizontal timing (0 = field 1, 1 = field 2) |
| vs_start_f1 | input | ST_W | Sync start code for field 1 (half lines minus one) |
| vs_start_f2 | input | ST_W | Sync start code for field 2 (half lines minus one) |
| vs_len | input | VLEN_W | Sync length in half lines |
| eq_en | input | 1 | Enables the equalization window |
| eq_start_f1 | input | ST_W | Equalization start code for field 1 |
| eq_start_f2 | input | ST_W | Equalization start code for field 2 |
| eq_len | input | ELEN_W | Equalization length in half lines |
| nbr_line | input | HL_W-1 | First line of the non-blank region |
| vb_start_all | input | 4*VBS_W | Four burst start codes in lines minus one, field k in slice k |
| vb_end_all | input | 4*VBE_W | Four burst end codes in lines minus one after `nbr_line`, field k in slice k |
| vsync_o | output | 1 | Vertical sync window |
| eq_o | output | 1 | Equalization window |
| vburst_o | output | 1 | Vertical colorburst enable |
| field_no | output | 2 | Field number within the four-field sequence |

## Verification
The sync window and the equalization window can both be open on the same half line. The first configuration places the field-1 equalization interval across the opening of the field-1 sync window, so both windows are active during those half lines. In each such cycle both outputs are compared against the bench's own model and must be high together. That overlap is reported under its own tag. The field-2 offsets in the same run keep the two windows apart, and disabling equalization afterwards shows the sync output continuing without it.

// File: rtl/ilace_vtimer_pkg.sv
package ilace_vtimer_pkg;

  localparam int FIELDS = 4;
  localparam int FLD_W  = $clog2(FIELDS);

  typedef logic [FLD_W-1:0] field_num_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilace_rst_sync.sv
module ilace_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_s = stage_q[1];

endmodule

// File: rtl/ilace_hl_counter.sv
module ilace_hl_counter
  import ilace_vtimer_pkg::*;
#(
  parameter int HL_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hl_tick,
  input  logic            field_id,
  output logic [HL_W-1:0] h_q,
  output logic            fid_q,
  output field_num_t      fnum_q
);

  localparam logic [HL_W-1:0] HL_MAX = '1;

  logic [HL_W-1:0] h_d;
  logic            fid_d;
  field_num_t      fnum_d;
  logic            boundary;

  // next-state
  always_comb begin
    h_d      = h_q;
    fid_d    = fid_q;
    fnum_d   = fnum_q;
    boundary = hl_tick && (field_id != fid_q);
    if (boundary) begin
      h_d    = '0;
      fid_d  = field_id;
      fnum_d = fnum_q + field_num_t'(1);
    end else if (hl_tick && (h_q != HL_MAX)) begin
      h_d    = h_q + HL_W'(1);
    end
  end

  // registers, enabled by the half-line tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      fid_q  <= 1'b0;
      fnum_q <= '0;
    end else if (hl_tick) begin
      h_q    <= h_d;
      fid_q  <= fid_d;
      fnum_q <= fnum_d;
    end
  end

endmodule

// File: rtl/ilace_window.sv
module ilace_window
  import ilace_vtimer_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int ST_W  = 7,
  parameter int LEN_W = 11
) (
  input  logic             en,
  input  logic [POS_W-1:0] pos,
  input  logic [ST_W-1:0]  start,
  input  logic [LEN_W-1:0] len,
  output logic             active
);

  localparam int SW = max2(max2(POS_W, ST_W), LEN_W) + 1;

  logic [SW-1:0] pos_x;
  logic [SW-1:0] beg_x;
  logic [SW-1:0] end_x;

  always_comb begin
    pos_x  = SW'(pos);
    beg_x  = SW'(start);
    end_x  = beg_x + SW'(len);
    active = en && (pos_x >= beg_x) && (pos_x < end_x);
  end

endmodule

// File: rtl/ilace_burst_sel.sv
module ilace_burst_sel
  import ilace_vtimer_pkg::*;
#(
  parameter int LN_W  = 10,
  parameter int VBS_W = 6,
  parameter int VBE_W = 8
) (
  input  field_num_t              fsel,
  input  logic [LN_W-1:0]         line,
  input  logic [LN_W-1:0]         nbr,
  input  logic [FIELDS*VBS_W-1:0] vbs_all,
  input  logic [FIELDS*VBE_W-1:0] vbe_all,
  output logic                    active
);

  localparam int BW = max2(max2(LN_W, VBS_W), VBE_W) + 1;

  logic [VBS_W-1:0] bs_arr [FIELDS];
  logic [VBE_W-1:0] be_arr [FIELDS];

  for (genvar k = 0; k < FIELDS; k++) begin : g_unpack
    assign bs_arr[k] = vbs_all[k*VBS_W +: VBS_W];
    assign be_arr[k] = vbe_all[k*VBE_W +: VBE_W];
  end

  logic [BW-1:0] line_x;
  logic [BW-1:0] beg_x;
  logic [BW-1:0] end_x;

  always_comb begin
    line_x = BW'(line);
    beg_x  = BW'(bs_arr[fsel]);
    end_x  = BW'(nbr) + BW'(be_arr[fsel]);
    active = (line_x >= beg_x) && (line_x <= end_x);
  end

endmodule

// File: rtl/ilace_vtimer.sv
module ilace_vtimer
  import ilace_vtimer_pkg::*;
#(
  parameter int HL_W   = 11,
  parameter int ST_W   = 7,
  parameter int VLEN_W = 11,
  parameter int ELEN_W = 7,
  parameter int VBS_W  = 6,
  parameter int VBE_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hl_tick,
  input  logic                    field_id,
  input  logic [ST_W-1:0]         vs_start_f1,
  input  logic [ST_W-1:0]         vs_start_f2,
  input  logic [VLEN_W-1:0]       vs_len,
  input  logic                    eq_en,
  input  logic [ST_W-1:0]         eq_start_f1,
  input  logic [ST_W-1:0]         eq_start_f2,
  input  logic [ELEN_W-1:0]       eq_len,
  input  logic [HL_W-2:0]         nbr_line,
  input  logic [FIELDS*VBS_W-1:0] vb_start_all,
  input  logic [FIELDS*VBE_W-1:0] vb_end_all,
  output logic                    vsync_o,
  output logic                    eq_o,
  output logic                    vburst_o,
  output logic [1:0]              field_no
);

  localparam int LN_W = HL_W - 1;

  logic            rst_s;
  logic [HL_W-1:0] h_q;
  logic            fid_q;
  field_num_t      fnum_q;
  logic [ST_W-1:0] vs_start_sel;
  logic [ST_W-1:0] eq_start_sel;

  ilace_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  ilace_hl_counter #(.HL_W(HL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .hl_tick  (hl_tick),
    .field_id (field_id),
    .h_q      (h_q),
    .fid_q    (fid_q),
    .fnum_q   (fnum_q)
  );

  assign vs_start_sel = fid_q ? vs_start_f2 : vs_start_f1;
  assign eq_start_sel = fid_q ? eq_start_f2 : eq_start_f1;

  ilace_window #(.POS_W(HL_W), .ST_W(ST_W), .LEN_W(VLEN_W)) u_vs_win (
    .en     (1'b1),
    .pos    (h_q),
    .start  (vs_start_sel),
    .len    (vs_len),
    .active (vsync_o)
  );

  ilace_window #(.POS_W(HL_W), .ST_W(ST_W), .LEN_W(ELEN_W)) u_eq_win (
    .en     (eq_en),
    .pos    (h_q),
    .start  (eq_start_sel),
    .len    (eq_len),
    .active (eq_o)
  );

  ilace_burst_sel #(.LN_W(LN_W), .VBS_W(VBS_W), .VBE_W(VBE_W)) u_burst (
    .fsel    (fnum_q),
    .line    (h_q[HL_W-1:1]),
    .nbr     (nbr_line),
    .vbs_all (vb_start_all),
    .vbe_all (vb_end_all),
    .active  (vburst_o)
  );

  assign field_no = fnum_q;

endmodule

// File: rtl/ilace_vtimer_chk.sv
module ilace_vtimer_chk #(
  parameter int HL_W = 11,
  parameter int ST_W = 7
) (
  input logic            clk,
  input logic            rst_s,
  input logic            hl_tick,
  input logic            field_id,
  input logic            fid_q,
  input logic [HL_W-1:0] h_q,
  input logic [1:0]      field_no,
  input logic            eq_en,
  input logic            eq_o,
  input logic            vsync_o,
  input logic [ST_W-1:0] vs_start_f1,
  input logic [ST_W-1:0] vs_start_f2
);

  localparam logic [HL_W-1:0] HL_MAX = '1;

  // R2: no tick, nothing moves
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !hl_tick |=> ($stable(h_q) && $stable(field_no) && $stable(fid_q)));

  // R2: plain tick steps the count
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (hl_tick && (field_id == fid_q) && (h_q != HL_MAX)) |=> (h_q == $past(h_q) + 1'b1));

  // R3: boundary restarts the count and takes the identifier
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (hl_tick && (field_id != fid_q)) |=> ((h_q == '0) && (fid_q == $past(field_id))));

  // R4: field number steps modulo four
  p_field_adv_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (hl_tick && (field_id != fid_q)) |=> (field_no == 2'($past(field_no) + 2'd1)));

  // R5: sync never opens before its field's start
  p_vs_after_start_r5: assert property (@(posedge clk) disable iff (!rst_s)
    vsync_o |-> (h_q >= HL_W'(fid_q ? vs_start_f2 : vs_start_f1)));

  // R6: equalization silent when disabled
  p_eq_off_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !eq_en |-> !eq_o);

endmodule

bind ilace_vtimer ilace_vtimer_chk #(.HL_W(HL_W), .ST_W(ST_W)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .hl_tick     (hl_tick),
  .field_id    (field_id),
  .fid_q       (fid_q),
  .h_q         (h_q),
  .field_no    (field_no),
  .eq_en       (eq_en),
  .eq_o        (eq_o),
  .vsync_o     (vsync_o),
  .vs_start_f1 (vs_start_f1),
  .vs_start_f2 (vs_start_f2)
);

// File: tb/ilace_vtimer_test.sv
`timescale 1ns/1ps
module ilace_vtimer_test;

  localparam int HL_W = 11;
  localparam int HMAX = (1 << HL_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hl_tick;
  logic        field_id;
  logic [6:0]  vs_start_f1, vs_start_f2, eq_start_f1, eq_start_f2;
  logic [10:0] vs_len;
  logic        eq_en;
  logic [6:0]  eq_len;
  logic [9:0]  nbr_line;
  logic [23:0] vb_start_all;
  logic [31:0] vb_end_all;
  logic        vsync_o, eq_o, vburst_o;
  logic [1:0]  field_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int mh = 0, mfid = 0, mf = 0;
  int bs [4];
  int be [4];

  always #2.5 clk = ~clk;

  ilace_vtimer uut (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .field_id(field_id),
    .vs_start_f1(vs_start_f1), .vs_start_f2(vs_start_f2), .vs_len(vs_len),
    .eq_en(eq_en), .eq_start_f1(eq_start_f1), .eq_start_f2(eq_start_f2),
    .eq_len(eq_len), .nbr_line(nbr_line), .vb_start_all(vb_start_all),
    .vb_end_all(vb_end_all), .vsync_o(vsync_o), .eq_o(eq_o),
    .vburst_o(vburst_o), .field_no(field_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d field=%0d)", tag, act, exp, mh, mf);
    end
  endtask

  task automatic pack_bursts();
    for (int k = 0; k < 4; k++) begin
      vb_start_all[k*6 +: 6] = 6'(bs[k]);
      vb_end_all[k*8 +: 8]   = 8'(be[k]);
    end
  endtask

  task automatic compare();
    int vst, est, ln, e_vs, e_eq, e_b;
    vst  = mfid ? int'(vs_start_f2) : int'(vs_start_f1);
    est  = mfid ? int'(eq_start_f2) : int'(eq_start_f1);
    e_vs = (mh >= vst && mh < vst + int'(vs_len)) ? 1 : 0;
    e_eq = (eq_en && mh >= est && mh < est + int'(eq_len)) ? 1 : 0;
    ln   = mh / 2;
    e_b  = (ln >= bs[mf] && ln <= int'(nbr_line) + be[mf]) ? 1 : 0;
    chk("R3 R4 field_no", int'(field_no), mf);
    chk("R2 R3 R5 vsync_o", int'(vsync_o), e_vs);
    chk("R6 eq_o", int'(eq_o), e_eq);
    chk("R2 R7 vburst_o", int'(vburst_o), e_b);
    if (e_vs && e_eq) chk("R8 overlap", int'({vsync_o, eq_o}), 3);
  endtask

  task automatic step(input bit t, input bit f);
    hl_tick  = t;
    field_id = f;
    @(posedge clk);
    #1;
    if (t) begin
      if (int'(f) != mfid) begin
        mh = 0; mfid = int'(f); mf = (mf + 1) % 4;
      end else if (mh < HMAX) begin
        mh++;
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hl_tick = 1'b0; field_id = 1'b0;
    vs_start_f1 = 7'd5; vs_start_f2 = 7'd6; vs_len = 11'd6;
    eq_en = 1'b1; eq_start_f1 = 7'd2; eq_start_f2 = 7'd0;
    eq_len = 7'd5;
    nbr_line = 10'd5;
    bs = '{1, 2, 3, 4};
    be = '{2, 3, 1, 0};
    pack_bursts();
    repeat (4) @(negedge clk);
    chk("R1 field_no in reset", int'(field_no), 0);
    compare();
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0);
    chk("R1 field_no after release", int'(field_no), 0);

    // phase 1: ticks every other cycle, equalization on, identifier glitches
    for (int k = 0; k < 7; k++) begin
      bit f = k[0];
      for (int i = 0; i < 30 + k; i++) begin
        step(1'b1, f);
        if (i == 10) step(1'b0, ~f);  // R3: change without a tick is ignored
        else         step(1'b0, f);
      end
    end

    // phase 2: equalization off, new sync and burst schedule, tick every cycle
    eq_en = 1'b0; vs_start_f1 = 7'd0; vs_len = 11'd3;
    nbr_line = 10'd3;
    bs = '{0, 5, 2, 6};
    be = '{4, 0, 8, 2};
    pack_bursts();
    for (int k = 0; k < 5; k++) begin
      bit f = ~k[0];
      for (int i = 0; i < 36; i++) step(1'b1, f);
    end

    // phase 3: long field to reach saturation of the half-line count
    nbr_line = 10'd1000;
    bs = '{0, 0, 0, 0};
    be = '{30, 30, 30, 30};
    pack_bursts();
    for (int i = 0; i < 2100; i++) step(1'b1, field_id);
    for (int i = 0; i < 6; i++) step(1'b1, ~field_id);
    repeat (3) step(1'b0, field_id);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule